// File: doc/BRIEF.md
# Multi-Mode Serial Port

This block is a serial port with four operating modes that share one transmit shifter. Mode 0 is a synchronous shift register. The port drives the shift clock on its transmit pin and moves data on its bidirectional data pin. Modes 1 to 3 are asynchronous. Mode 1 sends and receives 10-bit frames. Modes 2 and 3 send and receive 11-bit frames whose ninth data bit is programmable. The bit rate comes from one of two sources: a fixed division of the block clock, or an overflow pulse from an external timer. A rate-doubling bit can halve either divider.

Software runs the port through a control word and a data path. Writing the transmit data starts a frame. A received byte appears on the receive buffer output. Two flags report that a transmission or a reception has finished. Hardware only ever sets these flags. Software must clear them by writing the control word.

Top module: `multimode_sio`

## Requirements
- R1: The control word read back on `ctrl_q` and written through `ctrl_wdata` has these fields:
  - [1:0] mode (0 = shift, 1 = 10-bit UART at timer rate, 2 = 11-bit UART at fixed rate, 3 = 11-bit UART at timer rate)
  - [2] receive enable
  - [3] transmit ninth bit
  - [4] received ninth bit
  - [5] transmit-done flag
  - [6] receive-done flag
  - [7] rate doubling

  After reset, `ctrl_q` and `rx_buf` are 0, `txd` is 1 and `rxd_oe` is 0.
- R2: In mode 0, a data write shifts 8 bits out on `rxd_out`, LSB first, with `rxd_oe` high. Each bit lasts SHIFT_DIV clocks. During each bit, `txd` is low for the first SHIFT_DIV/2 clocks and high for the rest. The transmit-done flag sets when the eighth bit ends.
- R3: In mode 0, a reception starts only when receive enable is 1 and the receive-done flag is 0. The port samples `rxd_in` as `txd` rises, LSB first. After 8 bits it loads `rx_buf` and sets the receive-done flag.
- R4: In mode 1, a data write sends start 0, 8 data bits LSB first, then stop 1. Modes 2 and 3 insert the transmit ninth bit before the stop bit. The line idles at 1.
- R5: In modes 1 to 3, the transmit-done flag sets at the start of the stop bit.
- R6: Mode 2 bits last OSC_UART_DIV clocks, or half that when rate doubling is 1. Mode 1 and mode 3 bits last 32 timer pulses, or 16 when rate doubling is 1.
- R7: In modes 1 to 3, a received frame loads its 8 data bits into `rx_buf`. The received ninth bit takes the stop bit in mode 1 and the ninth data bit in modes 2 and 3. The receive-done flag sets at the stop-bit sample.
- R8: A low pulse on `rxd_in` that has ended by the middle of a start bit is dropped: no flag, and `rx_buf` is unchanged.
- R9: With receive enable 0, frames on `rxd_in` in modes 1 to 3 leave `rx_buf` and the receive-done flag unchanged.
- R10: Both done flags stay set until a control write clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_tick | input | 1 | One-clock pulse per timer overflow |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write value |
| ctrl_q | output | 8 | Control word and flags |
| data_wr | input | 1 | Transmit data write strobe; starts a frame |
| data_wdata | input | DATA_W | Transmit data |
| rx_buf | output | DATA_W | Last received data |
| txd | output | 1 | Serial output, or shift clock in mode 0 |
| rxd_in | input | 1 | Serial input |
| rxd_out | output | 1 | Mode 0 shift data out |
| rxd_oe | output | 1 | Output enable for `rxd_out` |

## Verification
The bench uses the default parameters: SHIFT_DIV 12, OSC_UART_DIV 64, 16 samples per bit and 8 data bits. The timer pulse arrives every second clock, so every UART bit lasts either 32 or 64 clocks. With such short bits, the bench can sweep all 256 byte values through both mode-0 directions. It can also run every pairing of UART mode and rate doubling through transmit and receive, with the ninth bit toggling. Each bit position and each flag time is then compared with a value computed from these bit lengths.

// File: rtl/multimode_sio.sv
module multimode_sio #(
  parameter int DATA_W       = 8,
  parameter int SHIFT_DIV    = 12,
  parameter int OSC_UART_DIV = 64,
  parameter int OVS          = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_q,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [DATA_W-1:0] rx_buf,
  output logic              txd,
  input  logic              rxd_in,
  output logic              rxd_out,
  output logic              rxd_oe
);
  localparam int FW  = DATA_W + 3;
  localparam int RW  = DATA_W + 2;
  localparam int BW  = $clog2(DATA_W + 3);
  localparam int OW  = $clog2(OVS);
  localparam int CW0 = $clog2(SHIFT_DIV);
  localparam int PW  = $clog2(OSC_UART_DIV / OVS + 1);

  localparam logic [OW-1:0]  OS_END  = OW'(OVS - 1);
  localparam logic [OW-1:0]  OS_MID  = OW'(OVS / 2 - 1);
  localparam logic [CW0-1:0] C0_END  = CW0'(SHIFT_DIV - 1);
  localparam logic [CW0-1:0] C0_RISE = CW0'(SHIFT_DIV / 2 - 1);
  localparam logic [CW0-1:0] C0_HALF = CW0'(SHIFT_DIV / 2);
  localparam logic [PW-1:0]  PRE_S   = PW'(OSC_UART_DIV / OVS - 1);
  localparam logic [PW-1:0]  PRE_F   = PW'(OSC_UART_DIV / (2 * OVS) - 1);

  logic [1:0] mode;
  logic ren, tb8, rb8, ti, ri, smod;

  logic [PW-1:0] pre;
  logic tdiv, pre_end, os_tick;

  logic              tx_busy, sh_rx;
  logic [FW-1:0]     tx_sh;
  logic [BW-1:0]     tx_bit, tx_last;
  logic [OW-1:0]     tx_os;
  logic [CW0-1:0]    c0;
  logic [DATA_W-1:0] rx0_sh;
  logic m0_end, m0_rise, m0_rx_go, bit_end, ti_set, ri0_set;

  logic [2:0]    rsync;
  logic          rx_s, fall, rx_busy, rx_done;
  logic [OW-1:0] rx_os;
  logic [BW-1:0] rx_bit, rx_last;
  logic [RW-2:0] rx_sh;
  logic [RW-1:0] rx_nv;

  assign ctrl_q = {smod, ri, ti, rb8, tb8, ren, mode};

  // bit-rate sample tick: OVS ticks per bit
  assign pre_end = (pre == (smod ? PRE_F : PRE_S));
  assign os_tick = (mode == 2'd2) ? pre_end : (mode[0] & tmr_tick & (smod | tdiv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      tdiv <= 1'b0;
    end else begin
      pre <= (mode == 2'd2 && !pre_end) ? pre + 1'b1 : '0;
      if (tmr_tick) tdiv <= ~tdiv;
    end
  end

  // shared shifter: all transmit modes plus mode 0 receive
  assign m0_end   = (c0 == C0_END);
  assign m0_rise  = (c0 == C0_RISE);
  assign m0_rx_go = !tx_busy && mode == 2'd0 && ren && !ri;
  assign tx_last  = (mode == 2'd0) ? BW'(DATA_W - 1) :
                    (mode[1] ? BW'(DATA_W + 2) : BW'(DATA_W + 1));
  assign bit_end  = tx_busy && ((mode == 2'd0) ? m0_end : (os_tick && tx_os == OS_END));
  assign ti_set   = bit_end && !sh_rx && !data_wr &&
                    ((mode == 2'd0) ? (tx_bit == tx_last) : (tx_bit == tx_last - 1'b1));
  assign ri0_set  = bit_end && sh_rx && !data_wr && (tx_bit == tx_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      sh_rx   <= 1'b0;
      tx_sh   <= '1;
      tx_bit  <= '0;
      tx_os   <= '0;
      c0      <= '0;
      rx0_sh  <= '0;
    end else if (data_wr) begin
      tx_busy <= 1'b1;
      sh_rx   <= 1'b0;
      tx_bit  <= '0;
      tx_os   <= '0;
      c0      <= '0;
      tx_sh   <= (mode == 2'd0) ? {3'b111, data_wdata}
                                : {1'b1, (mode[1] ? tb8 : 1'b1), data_wdata, 1'b0};
    end else if (m0_rx_go) begin
      tx_busy <= 1'b1;
      sh_rx   <= 1'b1;
      tx_bit  <= '0;
      c0      <= '0;
    end else if (tx_busy) begin
      if (mode == 2'd0) begin
        c0 <= m0_end ? '0 : c0 + 1'b1;
        if (sh_rx && m0_rise) rx0_sh <= {rxd_in, rx0_sh[DATA_W-1:1]};
      end else if (os_tick) begin
        tx_os <= tx_os + 1'b1;
      end
      if (bit_end) begin
        tx_sh <= {1'b1, tx_sh[FW-1:1]};
        if (tx_bit == tx_last) tx_busy <= 1'b0;
        else tx_bit <= tx_bit + 1'b1;
      end
    end
  end

  assign rxd_oe  = tx_busy && mode == 2'd0 && !sh_rx;
  assign rxd_out = rxd_oe ? tx_sh[0] : 1'b1;
  assign txd     = !tx_busy ? 1'b1 : ((mode == 2'd0) ? (c0 >= C0_HALF) : tx_sh[0]);

  // asynchronous receiver
  assign rx_s    = rsync[1];
  assign fall    = rsync[2] & ~rsync[1];
  assign rx_last = mode[1] ? BW'(DATA_W + 2) : BW'(DATA_W + 1);
  assign rx_nv   = {rx_s, rx_sh};
  assign rx_done = rx_busy && mode != 2'd0 && os_tick && rx_bit != '0 &&
                   rx_os == OS_END && rx_bit == rx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync   <= 3'b111;
      rx_busy <= 1'b0;
      rx_os   <= '0;
      rx_bit  <= '0;
      rx_sh   <= '0;
    end else begin
      rsync <= {rsync[1:0], rxd_in};
      if (!rx_busy) begin
        if (fall && ren && mode != 2'd0) begin
          rx_busy <= 1'b1;
          rx_os   <= '0;
          rx_bit  <= '0;
        end
      end else if (mode == 2'd0) begin
        rx_busy <= 1'b0;
      end else if (os_tick) begin
        if (rx_bit == '0) begin
          if (rx_os == OS_MID) begin
            if (rx_s) rx_busy <= 1'b0;
            else begin
              rx_bit <= 1'b1;
              rx_os  <= '0;
            end
          end else begin
            rx_os <= rx_os + 1'b1;
          end
        end else begin
          rx_os <= rx_os + 1'b1;
          if (rx_os == OS_END) begin
            rx_sh <= rx_nv[RW-1:1];
            if (rx_bit == rx_last) rx_busy <= 1'b0;
            else rx_bit <= rx_bit + 1'b1;
          end
        end
      end
    end
  end

  // control word and flags; hardware set wins over a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {smod, ri, ti, rb8, tb8, ren, mode} <= '0;
      rx_buf <= '0;
    end else begin
      if (ctrl_wr) {smod, ri, ti, rb8, tb8, ren, mode} <= ctrl_wdata;
      if (ti_set) ti <= 1'b1;
      if (ri0_set) begin
        ri     <= 1'b1;
        rx_buf <= rx0_sh;
      end
      if (rx_done) begin
        ri     <= 1'b1;
        rx_buf <= mode[1] ? rx_nv[DATA_W-1:0] : rx_nv[DATA_W:1];
        rb8    <= mode[1] ? rx_nv[DATA_W] : rx_nv[DATA_W+1];
      end
    end
  end
endmodule

// File: rtl/multimode_sio_chk.sv
module multimode_sio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_q,
  input logic       ctrl_wr,
  input logic       txd,
  input logic       rxd_oe,
  input logic       tx_busy
);
  AST_SHIFT_DRIVE_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_oe |-> (ctrl_q[1:0] == 2'd0)); // R2

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R4

  AST_TI_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_q[5]) && ctrl_q[1:0] != 2'd0 && !$past(ctrl_wr)) |-> txd); // R5

  AST_TI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[5] && !ctrl_wr) |=> ctrl_q[5]); // R10

  AST_RI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && !ctrl_wr) |=> ctrl_q[6]); // R10
endmodule

bind multimode_sio multimode_sio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr),
  .txd(txd), .rxd_oe(rxd_oe), .tx_busy(tx_busy)
);

// File: tb/multimode_sio_test.sv
module multimode_sio_test;
  logic clk = 1'b0, rst_n = 1'b0, tmr_tick = 1'b0;
  logic ctrl_wr = 1'b0, data_wr = 1'b0, rxd_in = 1'b1;
  logic [7:0] ctrl_wdata = '0, data_wdata = '0, ctrl_q, rx_buf;
  logic txd, rxd_out, rxd_oe;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  multimode_sio uut (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .data_wr(data_wr),
    .data_wdata(data_wdata), .rx_buf(rx_buf), .txd(txd), .rxd_in(rxd_in),
    .rxd_out(rxd_out), .rxd_oe(rxd_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [7:0] cw(int m, int s, int rn, int t9, int ti, int ri);
    return {s[0], ri[0], ti[0], 1'b0, t9[0], rn[0], m[1:0]};
  endfunction

  function automatic int bitlen(int m, int s);
    if (m == 0) return 12;
    if (m == 2) return s ? 32 : 64;
    return (s ? 16 : 32) * 2;
  endfunction

  function automatic logic [7:0] pat(int k);
    case (k)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hA5;
      default: return 8'h3C;
    endcase
  endfunction

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  initial forever begin
    @(negedge clk); tmr_tick = ~tmr_tick;
  end

  task automatic uart_tx(input int m, input int s, input logic [7:0] d, input logic t9);
    int bl, nb, p, ti_cyc;
    logic [10:0] fr;
    bl = bitlen(m, s); nb = (m >= 2) ? 11 : 10; p = bl / 16; ti_cyc = -1;
    fr = {1'b1, (m >= 2) ? t9 : 1'b1, d, 1'b0};
    wr_ctrl(cw(m, s, 0, t9, 0, 0));
    @(negedge clk); data_wr = 1'b1; data_wdata = d;
    @(negedge clk); data_wr = 1'b0;
    for (int c = 1; c <= nb * bl + 2; c++) begin
      if (ctrl_q[5] === 1'b1 && ti_cyc < 0) ti_cyc = c;
      if (c % bl == bl / 2) begin
        chk(txd === fr[c / bl], $sformatf("R4 mode %0d bit %0d", m, c / bl), txd, fr[c / bl]);
        if (c / bl == nb - 2) chk(ctrl_q[5] === 1'b0, "R5 TI before stop", ctrl_q[5], 0);
        if (c / bl == nb - 1) chk(ctrl_q[5] === 1'b1, "R5 TI in stop", ctrl_q[5], 1);
      end
      @(negedge clk);
    end
    chk(ti_cyc >= (nb - 1) * bl - p + 2 && ti_cyc <= (nb - 1) * bl + 1,
        $sformatf("R6 TI time mode %0d smod %0d", m, s), ti_cyc, (nb - 1) * bl);
    chk(ctrl_q[5] === 1'b1 && txd === 1'b1, "R10 TI held, line idle", {ctrl_q[5], txd}, 2'b11);
    wr_ctrl(cw(m, s, 0, 0, 0, 0));
    chk(ctrl_q[5] === 1'b0, "R10 TI cleared by write", ctrl_q[5], 0);
  endtask

  task automatic drive_bit(input logic v, input int bl);
    rxd_in = v;
    repeat (bl) @(negedge clk);
  endtask

  task automatic send_frame(input int m, input int s, input logic [7:0] d, input logic t9);
    int bl;
    bl = bitlen(m, s);
    @(negedge clk);
    drive_bit(1'b0, bl);
    for (int k = 0; k < 8; k++) drive_bit(d[k], bl);
    if (m >= 2) drive_bit(t9, bl);
    drive_bit(1'b1, bl);
    repeat (4) @(negedge clk);
  endtask

  task automatic uart_rx(input int m, input int s, input logic [7:0] d, input logic t9);
    wr_ctrl(cw(m, s, 1, 0, 0, 0));
    send_frame(m, s, d, t9);
    chk(ctrl_q[6] === 1'b1, $sformatf("R7 RI mode %0d smod %0d", m, s), ctrl_q[6], 1);
    chk(rx_buf === d, $sformatf("R7 data mode %0d smod %0d", m, s), rx_buf, d);
    chk(ctrl_q[4] === ((m >= 2) ? t9 : 1'b1), $sformatf("R7 ninth bit mode %0d", m),
        ctrl_q[4], (m >= 2) ? t9 : 1'b1);
    repeat (20) @(negedge clk);
    chk(ctrl_q[6] === 1'b1, "R10 RI held", ctrl_q[6], 1);
    wr_ctrl(cw(m, s, 1, 0, 0, 0));
    chk(ctrl_q[6] === 1'b0, "R10 RI cleared by write", ctrl_q[6], 0);
  endtask

  task automatic m0_tx(input logic [7:0] d);
    int cnt;
    @(negedge clk); data_wr = 1'b1; data_wdata = d;
    @(negedge clk); data_wr = 1'b0;
    for (int k = 0; k < 8; k++) begin
      while (txd !== 1'b0) @(negedge clk);
      cnt = 0;
      while (txd !== 1'b1) begin @(negedge clk); cnt++; end
      chk(cnt == 6, "R2 shift clock low phase", cnt, 6);
      chk(rxd_oe === 1'b1 && rxd_out === d[k], $sformatf("R2 shift bit %0d", k),
          {rxd_oe, rxd_out}, {1'b1, d[k]});
    end
    repeat (10) @(negedge clk);
    chk(ctrl_q[5] === 1'b1 && rxd_oe === 1'b0 && txd === 1'b1, "R2 TI after 8 bits",
        {ctrl_q[5], rxd_oe, txd}, 3'b101);
    wr_ctrl(cw(0, 0, 0, 0, 0, 0));
  endtask

  task automatic m0_rx(input logic [7:0] d);
    wr_ctrl(cw(0, 0, 1, 0, 0, 0));
    for (int k = 0; k < 8; k++) begin
      while (txd !== 1'b0) @(negedge clk);
      rxd_in = d[k];
      while (txd !== 1'b1) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk(ctrl_q[6] === 1'b1 && rx_buf === d, "R3 shift receive", {ctrl_q[6], rx_buf}, {1'b1, d});
    wr_ctrl(cw(0, 0, 0, 0, 0, 0));
    rxd_in = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    bit held;
    repeat (5) @(negedge clk);
    chk(ctrl_q === 8'h00 && rx_buf === 8'h00, "R1 reset control and buffer", {ctrl_q, rx_buf}, 0);
    chk(txd === 1'b1 && rxd_oe === 1'b0, "R1 reset lines", {txd, rxd_oe}, 2'b10);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && ctrl_q === 8'h00, "R1 after reset release", {txd, ctrl_q}, 9'h100);

    for (int v = 0; v < 256; v++) m0_tx(v[7:0]);

    wr_ctrl(cw(0, 0, 1, 0, 0, 1));
    held = 1'b1;
    repeat (40) begin @(negedge clk); if (txd !== 1'b1) held = 1'b0; end
    chk(held, "R3 no shift receive while RI set", held, 1);
    wr_ctrl(cw(0, 0, 0, 0, 0, 0));
    for (int v = 0; v < 256; v++) m0_rx(v[7:0]);

    for (int m = 1; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++) begin
          uart_tx(m, s, pat(k), k[0]);
          uart_rx(m, s, pat((k + 1) % 4), ~k[0]);
        end

    wr_ctrl(cw(1, 0, 1, 0, 0, 0));
    @(negedge clk);
    drive_bit(1'b0, 16);
    drive_bit(1'b1, 160);
    chk(ctrl_q[6] === 1'b0 && rx_buf === pat(0), "R8 false start dropped",
        {ctrl_q[6], rx_buf}, {1'b0, pat(0)});
    send_frame(1, 0, 8'h96, 1'b0);
    chk(ctrl_q[6] === 1'b1 && rx_buf === 8'h96, "R8 receive after false start",
        {ctrl_q[6], rx_buf}, 9'h196);
    wr_ctrl(cw(3, 0, 0, 0, 0, 0));
    send_frame(3, 0, 8'h5A, 1'b1);
    chk(ctrl_q[6] === 1'b0 && rx_buf === 8'h96, "R9 frame ignored with receive off",
        {ctrl_q[6], rx_buf}, 9'h096);

    report();
  end
endmodule